// File: doc/BRIEF.md
# Dual-Bank Multi-Port Register File

This block is the shared data register file that sits between a set of parallel computation units and the data buses. It keeps two complete banks of sixteen 40-bit registers, a primary and an alternate. Only one bank is visible at a time. A single-cycle swap request changes which bank is visible, so an interrupt handler or a second task gets a clean working set without copying any register.

Six read ports and four write ports work in the same cycle. Reads are combinational from the visible bank. Writes land at the clock edge, so a result written in one cycle can be used as an operand by any unit in the next cycle. A write port can also store a 32-bit value. That value goes into the upper 32 bits of the register and the low 8 bits are cleared, which matches the layout of a 40-bit extended word.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset every register of both banks reads as zero and the primary bank is the visible one.
- R2: A full-width write (wr_en_i[p]=1, wr_narrow_i[p]=0) stores wr_data_i[p] into register wr_addr_i[p] of the visible bank. Every read port that addresses that register returns the value from the next cycle on.
- R3: A read in the same cycle as a write to the same register returns the value held before that write; there is no write-through bypass.
- R4: When swap_i is 1 at a clock edge, the visible bank toggles from that edge on. Reads and writes in the cycle that carries swap_i still use the bank that was visible before the swap.
- R5: The bank that is not visible keeps its contents unchanged. Swapping back returns exactly the values it held before.
- R6: When several write ports target the same register in one cycle, the port with the highest index wins.
- R7: A narrow write (wr_narrow_i[p]=1) stores {wr_data_i[p][31:0], 8'h00}. Bits 39:32 of the write data are ignored.
- R8: All six read ports work independently in one cycle. They may address different registers or the same register.
- R9: A write port whose wr_en_i bit is 0 changes no register, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| swap_i | input | 1 | Toggle the visible bank at the next edge |
| rd_addr_i | input | 6x4 | Register address of each read port |
| rd_data_o | output | 6x40 | Read data of each read port, from the visible bank |
| wr_en_i | input | 4 | Write enable of each write port |
| wr_narrow_i | input | 4 | 1: store 32-bit value in bits 39:8, clear bits 7:0 |
| wr_addr_i | input | 4x4 | Register address of each write port |
| wr_data_i | input | 4x40 | Write data of each write port |

## Verification
The clocked properties assume the inputs hold known values that change only between rising edges, and that reset is held long enough for the internal synchronizer to fill. The write-to-read property follows the highest-indexed write port into read port 0, comparing the read address one cycle later with the registered write address. It is therefore valid only if no swap arrives in the same cycle, which the property excludes in its antecedent. The stimulus drives every field from time zero, applies all changes on falling edges, keeps writes idle until the reset synchronizer has released, and mixes directed collisions, narrow writes and swaps with a long pseudo-random phase.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Which of the two banks is currently visible to the ports.
  typedef enum logic {
    BANK_PRI = 1'b0,
    BANK_ALT = 1'b1
  } bank_e;

endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  output rf_pkg::bank_e bank_o
);
  import rf_pkg::*;

  bank_e bank_q;
  bank_e bank_d;

  // Next-state: toggle on a swap request, otherwise hold.
  always_comb begin
    bank_d = bank_q;
    if (swap_i) begin
      bank_d = (bank_q == BANK_PRI) ? BANK_ALT : BANK_PRI;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= BANK_PRI;
    end else begin
      bank_q <= bank_d;
    end
  end

  assign bank_o = bank_q;

  // R4: a swap request changes the visible bank at the very next edge.
  a_r4_swap_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> (bank_o != $past(bank_o)));

  // R4: without a request the visible bank stays put.
  a_r4_hold_no_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(bank_o));

endmodule

// File: rtl/rf_wr_merge.sv
module rf_wr_merge #(
  parameter int unsigned WIDTH    = 40,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned NWR      = 4,
  parameter int unsigned AW       = 4,
  parameter int unsigned IDX      = 0
) (
  input  logic [NWR-1:0]            wr_en_i,
  input  logic [NWR-1:0][AW-1:0]    wr_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data_i,
  input  logic [NWR-1:0]            wr_narrow_i,
  output logic                      we_o,
  output logic [WIDTH-1:0]          d_o
);
  localparam int unsigned PAD = WIDTH - NARROW_W;

  logic [NWR-1:0] hit;
  logic [NWR-1:0] win;

  // Ports that address this register.
  always_comb begin
    for (int p = 0; p < NWR; p++) begin
      hit[p] = wr_en_i[p] && (wr_addr_i[p] == AW'(IDX));
    end
  end

  // Priority pick: highest-indexed hitting port owns the register.
  always_comb begin
    win = '0;
    for (int p = NWR - 1; p >= 0; p--) begin
      if (hit[p] && (win == '0)) begin
        win[p] = 1'b1;
      end
    end
  end

  // Data of the winner; narrow values are left-aligned with a cleared pad.
  always_comb begin
    we_o = |win;
    d_o  = '0;
    for (int p = 0; p < NWR; p++) begin
      if (win[p]) begin
        if (wr_narrow_i[p]) begin
          d_o = WIDTH'(wr_data_i[p][NARROW_W-1:0]) << PAD;
        end else begin
          d_o = wr_data_i[p];
        end
      end
    end
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned NREG  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic [NREG-1:0]            we_i,
  input  logic [NREG-1:0][WIDTH-1:0] d_i,
  output logic [NREG-1:0][WIDTH-1:0] q_o
);

  logic [NREG-1:0] en;

  // Only the visible bank accepts writes.
  assign en = we_i & {NREG{act_i}};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] nxt;

    always_comb begin
      nxt = q;
      if (en[r]) begin
        nxt = d_i[r];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        q <= nxt;
      end
    end

    assign q_o[r] = q;
  end

  // R5: a bank that is not visible never changes.
  a_r5_idle_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(q_o));

  // R9: with no register selected for writing, the bank holds.
  a_r9_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !(|we_i)) |=> $stable(q_o));

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned NREG  = 16,
  parameter int unsigned AW    = 4
) (
  input  rf_pkg::bank_e              bank_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [NREG-1:0][WIDTH-1:0] pri_i,
  input  logic [NREG-1:0][WIDTH-1:0] alt_i,
  output logic [WIDTH-1:0]           data_o
);
  import rf_pkg::*;

  // Combinational read of the visible bank: a same-cycle write is not seen.
  always_comb begin
    if (bank_i == BANK_ALT) begin
      data_o = alt_i[addr_i];
    end else begin
      data_o = pri_i[addr_i];
    end
  end

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
  parameter  int unsigned WIDTH    = 40,
  parameter  int unsigned NARROW_W = 32,
  parameter  int unsigned NREG     = 16,
  parameter  int unsigned NRD      = 6,
  parameter  int unsigned NWR      = 4,
  localparam int unsigned AW       = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      swap_i,
  input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
  output logic [NRD-1:0][WIDTH-1:0] rd_data_o,
  input  logic [NWR-1:0]            wr_en_i,
  input  logic [NWR-1:0]            wr_narrow_i,
  input  logic [NWR-1:0][AW-1:0]    wr_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data_i
);
  import rf_pkg::*;

  localparam int unsigned NBANK = 2;

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  // Visible-bank state.
  bank_e bank_q;

  rf_bank_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .swap_i (swap_i),
    .bank_o (bank_q)
  );

  // Per-register write resolution, shared by both banks.
  logic [NREG-1:0]            reg_we;
  logic [NREG-1:0][WIDTH-1:0] reg_d;

  for (genvar r = 0; r < NREG; r++) begin : g_merge
    rf_wr_merge #(
      .WIDTH    (WIDTH),
      .NARROW_W (NARROW_W),
      .NWR      (NWR),
      .AW       (AW),
      .IDX      (r)
    ) u_merge (
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .wr_narrow_i (wr_narrow_i),
      .we_o        (reg_we[r]),
      .d_o         (reg_d[r])
    );
  end

  // Storage: one bank instance per bank select value.
  logic [NBANK-1:0]                      bank_act;
  logic [NBANK-1:0][NREG-1:0][WIDTH-1:0] bank_q_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_act[b] = (bank_q == bank_e'(b));

    rf_bank #(
      .WIDTH (WIDTH),
      .NREG  (NREG)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .act_i  (bank_act[b]),
      .we_i   (reg_we),
      .d_i    (reg_d),
      .q_o    (bank_q_all[b])
    );
  end

  // Read ports.
  for (genvar k = 0; k < NRD; k++) begin : g_rd
    rf_rd_mux #(
      .WIDTH (WIDTH),
      .NREG  (NREG),
      .AW    (AW)
    ) u_rd (
      .bank_i (bank_q),
      .addr_i (rd_addr_i[k]),
      .pri_i  (bank_q_all[BANK_PRI]),
      .alt_i  (bank_q_all[BANK_ALT]),
      .data_o (rd_data_o[k])
    );
  end

  // R2 and R6: the highest write port always lands, and read port 0 sees it
  // one cycle later when it addresses the same register without a swap.
  a_r2_write_visible: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i[NWR-1] && !wr_narrow_i[NWR-1] && !swap_i)
    |=> ((rd_addr_i[0] != $past(wr_addr_i[NWR-1]))
         || (rd_data_o[0] == $past(wr_data_i[NWR-1]))));

  // R3: with no write and no swap, an unchanged address keeps its data.
  a_r3_quiet_read_stable: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!(|wr_en_i) && !swap_i)
    |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));

endmodule

// File: tb/test_dual_bank_regfile.sv
`timescale 1ns/100ps
module test_dual_bank_regfile;
  localparam int NREG  = 16;
  localparam int WIDTH = 40;
  localparam int NRD   = 6;
  localparam int NWR   = 4;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap = 1'b0;
  logic [NRD-1:0][AW-1:0]    rd_addr = '0;
  logic [NRD-1:0][WIDTH-1:0] rd_data;
  logic [NWR-1:0]            wr_en = '0;
  logic [NWR-1:0]            wr_narrow = '0;
  logic [NWR-1:0][AW-1:0]    wr_addr = '0;
  logic [NWR-1:0][WIDTH-1:0] wr_data = '0;

  always #2.5 clk = ~clk;

  dual_bank_regfile i_dual_bank_regfile (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .swap_i      (swap),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .wr_en_i     (wr_en),
    .wr_narrow_i (wr_narrow),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data)
  );

  // Staged stimulus for the next cycle.
  logic                      s_swap = 1'b0;
  logic [NRD-1:0][AW-1:0]    s_rd = '0;
  logic [NWR-1:0]            s_en = '0;
  logic [NWR-1:0]            s_nar = '0;
  logic [NWR-1:0][AW-1:0]    s_wa = '0;
  logic [NWR-1:0][WIDTH-1:0] s_wd = '0;

  // Reference model.
  logic [WIDTH-1:0] mdl [2][NREG];
  int act = 0;

  // Scoreboard queues.
  logic [WIDTH-1:0] exp_q [$];
  int               port_q [$];
  string            tag_q [$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic cycle(input string tag);
    @(negedge clk);
    swap = s_swap; rd_addr = s_rd; wr_en = s_en;
    wr_narrow = s_nar; wr_addr = s_wa; wr_data = s_wd;
    for (int r = 0; r < NRD; r++) begin
      exp_q.push_back(mdl[act][s_rd[r]]);
      port_q.push_back(r);
      tag_q.push_back(tag);
    end
    for (int p = 0; p < NWR; p++) begin
      if (s_en[p]) begin
        mdl[act][s_wa[p]] = s_nar[p] ? {s_wd[p][31:0], 8'h00} : s_wd[p];
      end
    end
    if (s_swap) act = 1 - act;
    s_swap = 1'b0; s_en = '0; s_nar = '0;
  endtask

  task automatic set_reads(input int base);
    for (int r = 0; r < NRD; r++) s_rd[r] = AW'((base + r) % NREG);
  endtask

  task automatic all_reads(input int a);
    for (int r = 0; r < NRD; r++) s_rd[r] = AW'(a);
  endtask

  task automatic wr(input int p, input int a, input logic [WIDTH-1:0] d, input logic nar);
    s_en[p] = 1'b1; s_wa[p] = AW'(a); s_wd[p] = d; s_nar[p] = nar;
  endtask

  // Monitor: compare queued expectations shortly before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (exp_q.size() > 0) begin
        logic [WIDTH-1:0] e;
        int p;
        string t;
        e = exp_q.pop_front(); p = port_q.pop_front(); t = tag_q.pop_front();
        n_chk++;
        if (rd_data[p] !== e) begin
          n_fail++;
          $display("FAIL %s port %0d actual=%h expected=%h", t, p, rd_data[p], e);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int a = 0; a < NREG; a++) mdl[b][a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: both banks start at zero, primary visible.
    for (int base = 0; base < NREG; base += NRD) begin set_reads(base); cycle("R1"); end
    s_swap = 1'b1; set_reads(0); cycle("R1");
    for (int base = 0; base < NREG; base += NRD) begin set_reads(base); cycle("R1"); end
    s_swap = 1'b1; cycle("R1");

    // R2: fill the primary bank through rotating ports.
    for (int a = 0; a < NREG; a++) begin
      wr(a % NWR, a, {8'(a + 1), 32'(a * 32'h0101_0101) ^ 32'hA5A5_0F0F}, 1'b0);
      set_reads(a); cycle("R2");
    end
    // R8: all ports on one register, then on distinct registers.
    all_reads(9); cycle("R8");
    set_reads(3); cycle("R8");
    set_reads(10); cycle("R8");

    // R3: same-cycle read sees the old value, next cycle the new one.
    wr(0, 3, 40'h12_3456_789A, 1'b0); all_reads(3); cycle("R3");
    cycle("R2");

    // R6: collisions resolved toward the highest port.
    for (int p = 0; p < NWR; p++) wr(p, 5, 40'hF0_0000_0000 | 40'(p), 1'b0);
    all_reads(5); cycle("R6");
    cycle("R6");
    wr(1, 6, 40'h11_1111_1111, 1'b0); wr(2, 6, 40'h22_2222_2222, 1'b0);
    all_reads(6); cycle("R6");
    cycle("R6");
    wr(0, 8, 40'h0A_0000_0001, 1'b0); wr(1, 8, 40'h0B_0000_0002, 1'b0);
    all_reads(8); cycle("R6");
    cycle("R6");

    // R7: narrow writes, alone and winning a collision.
    wr(1, 10, 40'hAB_1234_5678, 1'b1); all_reads(10); cycle("R7");
    cycle("R7");
    wr(0, 12, 40'hFF_FFFF_FFFF, 1'b0); wr(3, 12, 40'hCD_8765_4321, 1'b1);
    all_reads(12); cycle("R7");
    cycle("R7");

    // R9: disabled port with live address and data changes nothing.
    s_wa[2] = AW'(11); s_wd[2] = 40'hDE_ADBE_EF00; s_en = '0;
    all_reads(11); cycle("R9");
    cycle("R9");

    // R4: swap cycle still uses the primary bank for read and write.
    wr(0, 7, 40'h77_7777_7777, 1'b0); s_swap = 1'b1; all_reads(7); cycle("R4");
    cycle("R4");
    for (int a = 0; a < NREG; a += 3) begin
      wr(3, a, {8'h5C, 32'(a) * 32'h1357_9BDF}, 1'b0); set_reads(a); cycle("R4");
    end
    for (int base = 0; base < NREG; base += NRD) begin set_reads(base); cycle("R4"); end

    // R5: back to primary, earlier values intact; then alternate again.
    s_swap = 1'b1; set_reads(0); cycle("R5");
    for (int base = 0; base < NREG; base += NRD) begin set_reads(base); cycle("R5"); end
    s_swap = 1'b1; cycle("R5");
    for (int base = 0; base < NREG; base += NRD) begin set_reads(base); cycle("R5"); end

    // Mixed traffic.
    for (int i = 0; i < 600; i++) begin
      s_en = NWR'($urandom); s_nar = NWR'($urandom);
      for (int p = 0; p < NWR; p++) begin
        s_wa[p] = AW'($urandom); s_wd[p] = {8'($urandom), 32'($urandom)};
      end
      for (int r = 0; r < NRD; r++) s_rd[r] = AW'($urandom);
      s_swap = (($urandom % 8) == 0);
      cycle("R2");
    end

    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule